// File: doc/BRIEF.md
# Embedded Operation Status Generator

This block builds the word a host sees when it reads the device while an embedded program or erase runs. The operation engine supplies its busy flag, its operation type, the top bit of each byte of the data being programmed, the erase acceptance-window flag, and the masks of erasing and suspended sectors. The block decides for each host read whether the host sees array data or a status word. It keeps two toggle bits that advance once per qualified read. A registered ready/busy output shows whether an embedded operation is running.

A read is taken on the first clock cycle of each host read strobe. The word is captured at that edge and is shown on `rd_data` from the next cycle. It stays there until the next read, however long the strobe is held. The read address reaches the block only as its sector field, `rd_sect`. Bit i of `erase_mask` and `susp_mask` stands for sector i.

Top module: `opstat_gen`

## Requirements
- R1: After reset, `rd_data` is 0, `ready` is 1 and both toggle bits are 0.
- R2: `ready` is the inverse of `op_busy`, one clock later: low while an operation runs, high again the cycle after it ends.
- R3: During a program (`op_busy`=1, `op_erase`=0), bit 7 of a read is the complement of the programmed data's bit 7 (`prog_msbs[0]`). Once `op_busy` falls, reads return `array_data` unchanged.
- R4: During an erase, bit 7 of a status read is 0. After the erase ends, reads return `array_data`, so erased data (all ones) reads with bit 7 = 1.
- R5: Bit 6 of a status read holds the busy toggle. The toggle is 0 after reset and inverts after each qualified read during an operation. A read returns the value it had before that read.
- R6: A read strobe held for several cycles counts as one read. `rd_data` is captured on the strobe's first cycle, appears the next cycle and holds until the next strobe rising edge.
- R7: Bit 3 of a status read equals `win_open` during an erase, and is 0 during a program.
- R8: During an erase, only reads of sectors set in `erase_mask` return status and advance the bit 6 toggle. Reads of any other sector return `array_data` and leave the toggle alone.
- R9: With `op_busy`=0 and `erase_susp`=1, a read of a sector set in `susp_mask` returns bit 7 = 1, bit 6 = the held busy toggle and bit 2 = the suspend toggle. That read then inverts the suspend toggle; bit 2 is 0 after reset. Reads of other sectors return `array_data`.
- R10: With `word_mode`=1, the upper byte of a status word repeats the status in bits 15, 14, 11 and 10, with bit 15 built from `prog_msbs[1]`. With `word_mode`=0, the upper byte of a status word is 0. All other status bits are 0.
- R11: When idle (`op_busy`=0, and `erase_susp`=0 or the read sector is not suspended), a read returns `array_data` and neither toggle changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_busy | input | 1 | Embedded operation running |
| op_erase | input | 1 | 1 = erase, 0 = program |
| erase_susp | input | 1 | Erase is suspended |
| win_open | input | 1 | Sector-erase acceptance window open |
| prog_msbs | input | 2 | Programmed data bit 7 (bit 0) and bit 15 (bit 1) |
| erase_mask | input | NSECT | Sectors in the erase |
| susp_mask | input | NSECT | Sectors with suspended erase |
| rd_strobe | input | 1 | Host read strobe, level |
| rd_sect | input | SW | Sector field of the read address |
| word_mode | input | 1 | 16-bit bus organisation |
| array_data | input | 16 | Array data for the read address |
| rd_data | output | 16 | Read word |
| ready | output | 1 | Ready (1) / busy (0) |

## Verification
The bench holds a strobe for several cycles and then reads again. A design that took the level as the read would skip toggle values or change `rd_data` in the middle of a read. During an erase it reads a sector outside the erase between two status reads; a design that did not check the sector would advance bit 6 there or show status instead of array data. It flips the programmed bit 7 and the window flag between reads, and switches between byte and word modes, to catch an uninverted poll bit, a missing window bit, or a missing or wrong upper-byte mirror. In suspend it reads both suspended and other sectors, so a bit 2 toggle that runs on every read, or a bit 6 that keeps moving, is caught.

// File: rtl/opstat_pkg.sv
package opstat_pkg;
  localparam int WORD_W = 16;

  typedef enum logic [1:0] {
    VIEW_ARRAY = 2'd0,
    VIEW_BUSY  = 2'd1,
    VIEW_SUSP  = 2'd2
  } view_t;

  // status byte while an operation runs
  function automatic logic [7:0] busy_byte(logic data_msb, logic is_erase,
                                           logic tgl, logic win);
    logic [7:0] b;
    b    = 8'h00;
    b[7] = is_erase ? 1'b0 : ~data_msb;
    b[6] = tgl;
    b[3] = is_erase & win;
    return b;
  endfunction

  // status byte for a suspended sector
  function automatic logic [7:0] susp_byte(logic tgl6, logic tgl2);
    logic [7:0] b;
    b    = 8'h00;
    b[7] = 1'b1;
    b[6] = tgl6;
    b[2] = tgl2;
    return b;
  endfunction
endpackage

// File: rtl/opstat_rise.sv
module opstat_rise (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise
);
  logic lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;

  // R6: two consecutive cycles never both count as a read
  assert_single_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/opstat_tbit.sv
module opstat_tbit (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= 1'b0;
    else if (adv) q <= ~q;
  end

  // R5: toggle only moves on a qualified read
  assert_toggle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(q));
endmodule

// File: rtl/opstat_view.sv
module opstat_view
  import opstat_pkg::*;
#(
  parameter int NSECT = 8,
  localparam int SW = $clog2(NSECT)
) (
  input  logic              op_busy,
  input  logic              op_erase,
  input  logic              erase_susp,
  input  logic              win_open,
  input  logic [1:0]        prog_msbs,
  input  logic [NSECT-1:0]  erase_mask,
  input  logic [NSECT-1:0]  susp_mask,
  input  logic [SW-1:0]     rd_sect,
  input  logic              word_mode,
  input  logic [WORD_W-1:0] array_data,
  input  logic              tog6,
  input  logic              tog2,
  output view_t             view,
  output logic [WORD_W-1:0] word,
  output logic              qual6,
  output logic              qual2
);
  logic  in_erase, in_susp;
  logic [7:0] lo_b, hi_b;

  assign in_erase = erase_mask[rd_sect];
  assign in_susp  = susp_mask[rd_sect];

  always_comb begin
    if (op_busy)
      view = (op_erase && !in_erase) ? VIEW_ARRAY : VIEW_BUSY;
    else if (erase_susp && in_susp)
      view = VIEW_SUSP;
    else
      view = VIEW_ARRAY;
  end

  assign qual6 = (view == VIEW_BUSY);
  assign qual2 = (view == VIEW_SUSP);

  always_comb begin
    lo_b = 8'h00;
    hi_b = 8'h00;
    word = array_data;
    case (view)
      VIEW_BUSY: begin
        lo_b = busy_byte(prog_msbs[0], op_erase, tog6, win_open);
        hi_b = busy_byte(prog_msbs[1], op_erase, tog6, win_open);
        word = {word_mode ? hi_b : 8'h00, lo_b};
      end
      VIEW_SUSP: begin
        lo_b = susp_byte(tog6, tog2);
        hi_b = lo_b;
        word = {word_mode ? hi_b : 8'h00, lo_b};
      end
      default: word = array_data;
    endcase
  end
endmodule

// File: rtl/opstat_gen.sv
module opstat_gen
  import opstat_pkg::*;
#(
  parameter int NSECT = 8,
  localparam int SW = $clog2(NSECT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_busy,
  input  logic              op_erase,
  input  logic              erase_susp,
  input  logic              win_open,
  input  logic [1:0]        prog_msbs,
  input  logic [NSECT-1:0]  erase_mask,
  input  logic [NSECT-1:0]  susp_mask,
  input  logic              rd_strobe,
  input  logic [SW-1:0]     rd_sect,
  input  logic              word_mode,
  input  logic [WORD_W-1:0] array_data,
  output logic [WORD_W-1:0] rd_data,
  output logic              ready
);
  logic              rd_rise;
  view_t             view;
  logic [WORD_W-1:0] word;
  logic              qual6, qual2;
  logic [1:0]        tog, adv;

  opstat_rise u_rise (
    .clk(clk), .rst_n(rst_n), .lvl(rd_strobe), .rise(rd_rise)
  );

  opstat_view #(.NSECT(NSECT)) u_view (
    .op_busy(op_busy), .op_erase(op_erase), .erase_susp(erase_susp),
    .win_open(win_open), .prog_msbs(prog_msbs), .erase_mask(erase_mask),
    .susp_mask(susp_mask), .rd_sect(rd_sect), .word_mode(word_mode),
    .array_data(array_data), .tog6(tog[0]), .tog2(tog[1]),
    .view(view), .word(word), .qual6(qual6), .qual2(qual2)
  );

  // tog[0] = bit 6 busy toggle, tog[1] = bit 2 suspend toggle
  assign adv = {rd_rise & qual2, rd_rise & qual6};

  for (genvar g = 0; g < 2; g++) begin : g_tbit
    opstat_tbit u_tbit (.clk(clk), .rst_n(rst_n), .adv(adv[g]), .q(tog[g]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
      ready   <= 1'b1;
    end else begin
      ready <= ~op_busy;
      if (rd_rise) rd_data <= word;
    end
  end

  assert_busy_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    op_busy |=> !ready);

  assert_poll_inv_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rise && view == VIEW_BUSY && !op_erase) |=> rd_data[7] == ~$past(prog_msbs[0]));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_rise |=> $stable(rd_data));

  assert_array_pass_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rise && view == VIEW_ARRAY) |=> rd_data == $past(array_data));

  assert_erase_bit7_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rise && view == VIEW_BUSY && op_erase) |=> !rd_data[7]);
endmodule

// File: tb/tb_opstat_gen.sv
`timescale 1ns/1ps
module tb_opstat_gen;
  logic        clk = 0, rst_n = 0;
  logic        op_busy = 0, op_erase = 0, erase_susp = 0, win_open = 0;
  logic [1:0]  prog_msbs = 0;
  logic [7:0]  erase_mask = 0, susp_mask = 0;
  logic        rd_strobe = 0;
  logic [2:0]  rd_sect = 0;
  logic        word_mode = 0;
  logic [15:0] array_data = 16'h0000;
  logic [15:0] rd_data;
  logic        ready;

  int checks = 0, errors = 0;
  logic t6 = 0, t2 = 0;
  logic [15:0] v;

  always #2.5 clk = ~clk;

  opstat_gen dut (
    .clk(clk), .rst_n(rst_n), .op_busy(op_busy), .op_erase(op_erase),
    .erase_susp(erase_susp), .win_open(win_open), .prog_msbs(prog_msbs),
    .erase_mask(erase_mask), .susp_mask(susp_mask), .rd_strobe(rd_strobe),
    .rd_sect(rd_sect), .word_mode(word_mode), .array_data(array_data),
    .rd_data(rd_data), .ready(ready)
  );

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  // expected status word, built bit by bit from the requirements
  function automatic logic [15:0] exp_prog(logic d7, logic d15, logic tg, logic wm);
    logic [15:0] w = 16'h0;
    w[7] = !d7;  w[6] = tg;
    if (wm) begin w[15] = !d15; w[14] = tg; end
    return w;
  endfunction

  function automatic logic [15:0] exp_erase(logic tg, logic win, logic wm);
    logic [15:0] w = 16'h0;
    w[6] = tg; w[3] = win;
    if (wm) begin w[14] = tg; w[11] = win; end
    return w;
  endfunction

  function automatic logic [15:0] exp_susp(logic tg6, logic tg2, logic wm);
    logic [15:0] w = 16'h0;
    w[7] = 1; w[6] = tg6; w[2] = tg2;
    if (wm) begin w[15] = 1; w[14] = tg6; w[10] = tg2; end
    return w;
  endfunction

  task automatic rd(input logic [2:0] s, input int hold, output logic [15:0] r);
    @(negedge clk); rd_sect = s; rd_strobe = 1;
    @(negedge clk); r = rd_data;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk("R6 held strobe", rd_data, r);
    end
    rd_strobe = 0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 rd_data", rd_data, 16'h0);
    chk("R1 ready", {15'h0, ready}, 16'h1);
  endtask

  task automatic t_idle;
    array_data = 16'h1234;
    rd(3'd0, 0, v); chk("R11 idle array", v, 16'h1234);
    array_data = 16'hA5C3;
    rd(3'd6, 0, v); chk("R11 idle array 2", v, 16'hA5C3);
  endtask

  task automatic t_program;
    @(negedge clk); op_busy = 1; op_erase = 0; prog_msbs = 2'b01; win_open = 1;
    array_data = 16'h5555;
    @(negedge clk); chk("R2 busy", {15'h0, ready}, 16'h0);
    rd(3'd1, 0, v); chk("R5 R3 R7 poll 1", v, exp_prog(1, 0, t6, 0)); t6 = !t6;
    rd(3'd4, 0, v); chk("R5 poll 2", v, exp_prog(1, 0, t6, 0)); t6 = !t6;
    prog_msbs = 2'b00;
    rd(3'd4, 0, v); chk("R3 bit7 inverse", v, exp_prog(0, 0, t6, 0)); t6 = !t6;
    rd(3'd2, 4, v); chk("R6 long read", v, exp_prog(0, 0, t6, 0)); t6 = !t6;
    rd(3'd2, 0, v); chk("R6 after long read", v, exp_prog(0, 0, t6, 0)); t6 = !t6;
    word_mode = 1; prog_msbs = 2'b10;
    rd(3'd0, 0, v); chk("R10 word mirror", v, exp_prog(0, 1, t6, 1)); t6 = !t6;
    word_mode = 0;
    @(negedge clk); op_busy = 0; win_open = 0;
    @(negedge clk); chk("R2 ready", {15'h0, ready}, 16'h1);
    rd(3'd1, 0, v); chk("R3 done array", v, 16'h5555);
  endtask

  task automatic t_erase;
    @(negedge clk); op_busy = 1; op_erase = 1; erase_mask = 8'b0000_0100;
    win_open = 1; array_data = 16'h0F0F;
    rd(3'd2, 0, v); chk("R7 R4 erase window", v, exp_erase(t6, 1, 0)); t6 = !t6;
    win_open = 0;
    rd(3'd2, 0, v); chk("R7 window closed", v, exp_erase(t6, 0, 0)); t6 = !t6;
    rd(3'd5, 0, v); chk("R8 other sector", v, 16'h0F0F);
    rd(3'd2, 0, v); chk("R8 toggle held", v, exp_erase(t6, 0, 0)); t6 = !t6;
    word_mode = 1; win_open = 1;
    rd(3'd2, 0, v); chk("R10 erase word", v, exp_erase(t6, 1, 1)); t6 = !t6;
    word_mode = 0; win_open = 0;
    @(negedge clk); op_busy = 0; array_data = 16'hFFFF;
    rd(3'd2, 0, v); chk("R4 erased ones", v, 16'hFFFF);
  endtask

  task automatic t_suspend;
    @(negedge clk); erase_susp = 1; susp_mask = 8'b0000_1000; array_data = 16'h3C3C;
    rd(3'd3, 0, v); chk("R9 susp 1", v, exp_susp(t6, t2, 0)); t2 = !t2;
    rd(3'd3, 0, v); chk("R9 susp 2", v, exp_susp(t6, t2, 0)); t2 = !t2;
    rd(3'd1, 0, v); chk("R9 other sector", v, 16'h3C3C);
    word_mode = 1;
    rd(3'd3, 0, v); chk("R9 R10 susp word", v, exp_susp(t6, t2, 1)); t2 = !t2;
    word_mode = 0;
    @(negedge clk); erase_susp = 0;
    rd(3'd3, 0, v); chk("R11 resume idle", v, 16'h3C3C);
    @(negedge clk); erase_susp = 1;
    rd(3'd3, 0, v); chk("R11 toggles unchanged", v, exp_susp(t6, t2, 0)); t2 = !t2;
    erase_susp = 0;
  endtask

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_idle;
    t_program;
    t_erase;
    t_suspend;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule